// File: doc/BRIEF.md
# Curve25519 Field Multiplier with Shared 52-bit Multiply-Accumulate

This block multiplies two elements of the prime field with modulus 2^255 − 19, or squares one of them. Each operand arrives as five limbs with a 51-bit radix spacing. Every limb may be up to 52 bits wide, so one carry bit per limb is allowed. A single 52×52 multiplier is time-shared across a fixed schedule of steps. In each step the low or the high 52-bit half of one product is added into a bank of 64-bit accumulators.

High halves of the products, and terms that the radix split forces to double, go to a second, "doubled" accumulator bank. That bank is merged into the plain bank once, with a one-bit left shift. The five upper product columns are then folded back onto the lower five through multiplications by 19. The column above 2^459 needs a two-stage fold that ends at the lowest limb.

The result is five unreduced 64-bit limbs whose weighted sum is congruent to the product. This output can go directly to the next add or subtract stage in a field pipeline. A one-cycle `start` launches an operation and a one-cycle `done` marks the result as valid.

Top module: `fe25519_mac_mul`

## Requirements
- R1: While reset is held and right after its release, `busy` and `done` are 0 and every limb of `z_out` is 0.
- R2: In multiply mode (`square` low at start), the integer Z = Σ z_k·2^(51k) is congruent to X·Y modulo 2^255 − 19, where X = Σ x_k·2^(51k). Input limb k sits at bits [52k+51:52k] of `x_in`/`y_in` and output limb k sits at bits [64k+63:64k] of `z_out`.
- R3: Products that never reach past bit 255 appear without any fold. 1 × 1 yields limbs (1,0,0,0,0), listed from limb 0 upward.
- R4: A product landing exactly at weight 2^255 is folded by a factor 19 into limb 0. x4 = 1 with y1 = 1 (all other limbs 0) yields limbs (19,0,0,0,0).
- R5: The column at weight 2^459 is folded in two stages. x4 = y4 = 2^51 (all other limbs 0) yields limb 0 = 342 and limb 4 = 2^51, with the rest 0.
- R6: With `square` high at start, Z is congruent to X² modulo 2^255 − 19 and `y_in` has no influence. Squaring 1 yields limbs (1,0,0,0,0).
- R7: `done` is a single-cycle pulse. It rises exactly 68 clock edges after the accepting edge in multiply mode and 49 in square mode. `busy` is high in between and low when `done` is high.
- R8: `start`, `square`, `x_in` and `y_in` are ignored while `busy` is high. Neither the result nor the completion time changes.
- R9: After `done`, `z_out` holds its value until the next accepted start.
- R10: Limbs at the full 52-bit maximum 2^52 − 1 in every position are handled in both modes with the congruence of R2/R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch request, accepted only while idle |
| square | input | 1 | Operation select sampled with start: 1 = square `x_in`, 0 = multiply |
| x_in | input | 260 | First operand, five 52-bit limbs |
| y_in | input | 260 | Second operand, five 52-bit limbs (unused when squaring) |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle pulse when `z_out` becomes valid |
| z_out | output | 320 | Result, five unreduced 64-bit limbs |

## Verification
The completion pulse of one operation and the acceptance of the next start can fall in the same cycle. The unit is idle in its `done` cycle, so a start raised then is taken at once. The bench provokes this by launching a second operation in the very cycle where `done` is seen. It then judges three things: the first result as read at that moment, the second result's congruence, and the exact 68- or 49-cycle latency of the second operation. A separate run raises `start` with altered operands and mode in the middle of an operation and expects neither the result nor the timing to move.

// File: rtl/fe_mac_pkg.sv
package fe_mac_pkg;

    localparam int LIMB_W     = 52;
    localparam int ACC_W      = 64;
    localparam int NLIMB      = 5;
    localparam int NPROD      = 2 * NLIMB;
    localparam int NPAIR      = NLIMB * (NLIMB - 1) / 2;
    localparam int NFOLD      = 3 * (NLIMB - 1) + 4;
    localparam int NMUL_STEPS = 2 * NLIMB * NLIMB;
    localparam int NSQ2_STEPS = NPAIR + 2 * NLIMB;
    localparam int LAT_MUL    = NMUL_STEPS + NFOLD + 2;
    localparam int LAT_SQR    = NPAIR + 1 + NSQ2_STEPS + 1 + NFOLD + 1;
    localparam int CNT_W      = $clog2(NMUL_STEPS);
    localparam int LIDX_W     = $clog2(NLIMB);
    localparam int PIDX_W     = $clog2(NPROD);
    localparam int FOLD_MULT  = 19;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PROD,
        PH_SHIFT,
        PH_PROD2,
        PH_MERGE1,
        PH_FOLD,
        PH_MERGE2
    } phase_e;

    typedef enum logic {
        OPA_X,
        OPA_K
    } opa_e;

    typedef enum logic [2:0] {
        OPB_Y,
        OPB_X,
        OPB_Z,
        OPB_ZHI,
        OPB_TMP
    } opb_e;

    typedef struct packed {
        opa_e              a_src;
        logic [LIDX_W-1:0] a_idx;
        opb_e              b_src;
        logic [PIDX_W-1:0] b_idx;
        logic              hi_half;
        logic              dbl;
        logic [PIDX_W-1:0] dst;
    } step_t;

    typedef struct packed {
        phase_e                         phase;
        logic [CNT_W-1:0]               cnt;
        logic                           sq;
        logic                           done;
        logic [NLIMB-1:0][LIMB_W-1:0]   x;
        logic [NLIMB-1:0][LIMB_W-1:0]   y;
        logic [NPROD-1:0][ACC_W-1:0]    c1;
        logic [NPROD-1:0][ACC_W-1:0]    c2;
    } mac_state_t;

endpackage

// File: rtl/fe_mul52.sv
module fe_mul52 #(
    parameter int W = 52
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] lo,
    output logic [W-1:0] hi
);
    logic [2*W-1:0] prod;

    assign prod = (2*W)'(a) * (2*W)'(b);
    assign lo   = prod[W-1:0];
    assign hi   = prod[2*W-1:W];
endmodule

// File: rtl/fe_step_decode.sv
module fe_step_decode import fe_mac_pkg::*; (
    input  phase_e           phase,
    input  logic             square,
    input  logic [CNT_W-1:0] cnt,
    output step_t            st
);
    int c;
    int pi;
    int pj;
    int q;
    int p;
    int d;
    int r;

    always_comb begin
        st       = '0;
        st.a_src = OPA_X;
        st.b_src = OPB_Y;
        c  = int'(cnt);
        pi = 0;
        pj = 1;
        q  = 0;
        p  = 0;
        d  = 0;
        r  = 0;
        // enumerate cross pairs i<j in a fixed order
        for (int i = 0; i < NLIMB; i++) begin
            for (int j = i + 1; j < NLIMB; j++) begin
                if (q == c) begin
                    pi = i;
                    pj = j;
                end
                q++;
            end
        end
        case (phase)
            PH_PROD: begin
                if (!square) begin
                    p          = c / 2;
                    st.a_idx   = LIDX_W'(p / NLIMB);
                    st.b_src   = OPB_Y;
                    st.b_idx   = PIDX_W'(p % NLIMB);
                    st.hi_half = cnt[0];
                    st.dbl     = cnt[0];
                    st.dst     = PIDX_W'(p / NLIMB + p % NLIMB + (cnt[0] ? 1 : 0));
                end else begin
                    // cross-term high halves: weight four, doubled bank pre-shift
                    st.a_idx   = LIDX_W'(pi);
                    st.b_src   = OPB_X;
                    st.b_idx   = PIDX_W'(pj);
                    st.hi_half = 1'b1;
                    st.dbl     = 1'b1;
                    st.dst     = PIDX_W'(pi + pj + 1);
                end
            end
            PH_PROD2: begin
                st.b_src = OPB_X;
                if (c < NPAIR) begin
                    st.a_idx = LIDX_W'(pi);
                    st.b_idx = PIDX_W'(pj);
                    st.dbl   = 1'b1;
                    st.dst   = PIDX_W'(pi + pj);
                end else if (c < NPAIR + NLIMB) begin
                    d          = c - NPAIR;
                    st.a_idx   = LIDX_W'(d);
                    st.b_idx   = PIDX_W'(d);
                    st.hi_half = 1'b1;
                    st.dbl     = 1'b1;
                    st.dst     = PIDX_W'(2 * d + 1);
                end else begin
                    d        = c - NPAIR - NLIMB;
                    st.a_idx = LIDX_W'(d);
                    st.b_idx = PIDX_W'(d);
                    st.dst   = PIDX_W'(2 * d);
                end
            end
            PH_FOLD: begin
                st.a_src = OPA_K;
                if (c < 3 * (NLIMB - 1)) begin
                    d        = c / 3;
                    r        = c % 3;
                    st.b_idx = PIDX_W'(NLIMB + d);
                    case (r)
                        0: begin
                            st.b_src = OPB_Z;
                            st.dst   = PIDX_W'(d);
                        end
                        1: begin
                            st.b_src   = OPB_Z;
                            st.hi_half = 1'b1;
                            st.dbl     = 1'b1;
                            st.dst     = PIDX_W'(d + 1);
                        end
                        default: begin
                            st.b_src = OPB_ZHI;
                            st.dbl   = 1'b1;
                            st.dst   = PIDX_W'(d + 1);
                        end
                    endcase
                end else begin
                    r        = c - 3 * (NLIMB - 1);
                    st.b_idx = PIDX_W'(NPROD - 1);
                    case (r)
                        0: begin
                            st.b_src = OPB_Z;
                            st.dst   = PIDX_W'(NLIMB - 1);
                        end
                        1: begin
                            st.b_src   = OPB_Z;
                            st.hi_half = 1'b1;
                            st.dbl     = 1'b1;
                            st.dst     = PIDX_W'(NPROD - 1);
                        end
                        2: begin
                            st.b_src = OPB_ZHI;
                            st.dbl   = 1'b1;
                            st.dst   = PIDX_W'(NPROD - 1);
                        end
                        default: begin
                            st.b_src = OPB_TMP;
                            st.dbl   = 1'b1;
                            st.dst   = '0;
                        end
                    endcase
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fe25519_mac_mul.sv
module fe25519_mac_mul import fe_mac_pkg::*; (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     square,
    input  logic [NLIMB*LIMB_W-1:0]  x_in,
    input  logic [NLIMB*LIMB_W-1:0]  y_in,
    output logic                     busy,
    output logic                     done,
    output logic [NLIMB*ACC_W-1:0]   z_out
);
    localparam logic [CNT_W-1:0]  LAST_MUL  = CNT_W'(NMUL_STEPS - 1);
    localparam logic [CNT_W-1:0]  LAST_SQ1  = CNT_W'(NPAIR - 1);
    localparam logic [CNT_W-1:0]  LAST_SQ2  = CNT_W'(NSQ2_STEPS - 1);
    localparam logic [CNT_W-1:0]  LAST_FOLD = CNT_W'(NFOLD - 1);
    localparam logic [LIMB_W-1:0] K_FOLD    = LIMB_W'(FOLD_MULT);

    mac_state_t        st_q;
    mac_state_t        st_d;
    step_t             step;
    logic [LIMB_W-1:0] op_a;
    logic [LIMB_W-1:0] op_b;
    logic [LIMB_W-1:0] mul_lo;
    logic [LIMB_W-1:0] mul_hi;
    logic [ACC_W-1:0]  term;

    fe_step_decode u_dec (
        .phase  (st_q.phase),
        .square (st_q.sq),
        .cnt    (st_q.cnt),
        .st     (step)
    );

    always_comb begin
        op_a = (step.a_src == OPA_K) ? K_FOLD : st_q.x[step.a_idx];
        case (step.b_src)
            OPB_X:   op_b = st_q.x[step.b_idx[LIDX_W-1:0]];
            OPB_Z:   op_b = st_q.c1[step.b_idx][LIMB_W-1:0];
            OPB_ZHI: op_b = LIMB_W'(st_q.c1[step.b_idx] >> LIMB_W);
            OPB_TMP: op_b = st_q.c2[NPROD-1][LIMB_W-1:0];
            default: op_b = st_q.y[step.b_idx[LIDX_W-1:0]];
        endcase
    end

    fe_mul52 #(.W(LIMB_W)) u_mul (
        .a  (op_a),
        .b  (op_b),
        .lo (mul_lo),
        .hi (mul_hi)
    );

    assign term = ACC_W'(step.hi_half ? mul_hi : mul_lo);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.x     = x_in;
                    st_d.y     = y_in;
                    st_d.sq    = square;
                    st_d.c1    = '0;
                    st_d.c2    = '0;
                    st_d.cnt   = '0;
                    st_d.phase = PH_PROD;
                end
            end
            PH_PROD, PH_PROD2, PH_FOLD: begin
                if (step.dbl) st_d.c2[step.dst] = st_q.c2[step.dst] + term;
                else          st_d.c1[step.dst] = st_q.c1[step.dst] + term;
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.phase == PH_PROD) begin
                    if (st_q.sq && st_q.cnt == LAST_SQ1) begin
                        st_d.cnt   = '0;
                        st_d.phase = PH_SHIFT;
                    end else if (!st_q.sq && st_q.cnt == LAST_MUL) begin
                        st_d.cnt   = '0;
                        st_d.phase = PH_MERGE1;
                    end
                end else if (st_q.phase == PH_PROD2) begin
                    if (st_q.cnt == LAST_SQ2) begin
                        st_d.cnt   = '0;
                        st_d.phase = PH_MERGE1;
                    end
                end else if (st_q.cnt == LAST_FOLD) begin
                    st_d.cnt   = '0;
                    st_d.phase = PH_MERGE2;
                end
            end
            PH_SHIFT: begin
                for (int k = 0; k < NPROD; k++) st_d.c2[k] = st_q.c2[k] << 1;
                st_d.phase = PH_PROD2;
            end
            PH_MERGE1: begin
                for (int k = 0; k < NPROD; k++) begin
                    st_d.c1[k] = st_q.c1[k] + (st_q.c2[k] << 1);
                    st_d.c2[k] = '0;
                end
                st_d.phase = PH_FOLD;
            end
            PH_MERGE2: begin
                for (int k = 0; k < NPROD; k++) begin
                    st_d.c1[k] = st_q.c1[k] + (st_q.c2[k] << 1);
                    st_d.c2[k] = '0;
                end
                st_d.done  = 1'b1;
                st_d.phase = PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = (st_q.phase != PH_IDLE);
    assign done = st_q.done;

    for (genvar k = 0; k < NLIMB; k++) begin : g_out
        assign z_out[k*ACC_W +: ACC_W] = st_q.c1[k];
    end
endmodule

// File: rtl/fe25519_mac_mul_chk.sv
module fe25519_mac_mul_chk import fe_mac_pkg::*; (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic                   square,
    input logic                   busy,
    input logic                   done,
    input logic [NLIMB*ACC_W-1:0] z_out
);
    logic [7:0] run_cnt;
    logic [7:0] run_lat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
            run_lat <= '0;
        end else if (start && !busy) begin
            run_cnt <= '0;
            run_lat <= square ? 8'(LAT_SQR) : 8'(LAT_MUL);
        end else if (busy) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R7
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == run_lat));

    // R8
    busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_cnt < run_lat));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && $past(!start)) |-> $stable(z_out));
endmodule

bind fe25519_mac_mul fe25519_mac_mul_chk chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .square (square),
    .busy   (busy),
    .done   (done),
    .z_out  (z_out)
);

// File: tb/fe25519_mac_mul_tb_top.sv
module fe25519_mac_mul_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 52;
    localparam int AW = 64;
    localparam int NL = 5;
    localparam int EXP_LAT_MUL = 68;
    localparam int EXP_LAT_SQR = 49;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             square = 1'b0;
    logic [NL*LW-1:0] x_in = '0;
    logic [NL*LW-1:0] y_in = '0;
    logic             busy;
    logic             done;
    logic [NL*AW-1:0] z_out;

    int n_chk = 0;
    int n_fail = 0;

    fe25519_mac_mul dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .square (square),
        .x_in   (x_in),
        .y_in   (y_in),
        .busy   (busy),
        .done   (done),
        .z_out  (z_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [575:0] prime();
        return (576'd1 << 255) - 576'd19;
    endfunction

    function automatic logic [575:0] in_value(input logic [NL*LW-1:0] v);
        logic [575:0] acc = '0;
        for (int k = 0; k < NL; k++) acc += 576'(v[k*LW +: LW]) << (51 * k);
        return acc;
    endfunction

    function automatic logic [575:0] out_value(input logic [NL*AW-1:0] v);
        logic [575:0] acc = '0;
        for (int k = 0; k < NL; k++) acc += 576'(v[k*AW +: AW]) << (51 * k);
        return acc;
    endfunction

    function automatic logic [NL*LW-1:0] rand_limbs();
        logic [NL*LW-1:0] v;
        for (int k = 0; k < NL; k++) v[k*LW +: LW] = LW'({$urandom(), $urandom()});
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [575:0] act,
                         input logic [575:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called and returns at a falling edge; start goes high at once.
    task automatic run_op(input logic [NL*LW-1:0] a, input logic [NL*LW-1:0] b,
                          input logic sq, input bit disturb,
                          output logic [NL*AW-1:0] z, output int lat);
        x_in = a;
        y_in = b;
        square = sq;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 300) begin
            if (disturb && lat == 4) begin
                start = 1'b1;
                x_in = ~a;
                y_in = ~b;
                square = ~sq;
            end
            if (disturb && lat == 8) start = 1'b0;
            @(negedge clk);
            lat++;
        end
        z = z_out;
    endtask

    task automatic check_congruent(input string tag, input logic [NL*LW-1:0] a,
                                   input logic [NL*LW-1:0] b, input logic [NL*AW-1:0] z);
        logic [575:0] exp;
        logic [575:0] act;
        exp = (in_value(a) * in_value(b)) % prime();
        act = out_value(z) % prime();
        check(act == exp, tag, act, exp);
    endtask

    task automatic test_reset();
        // R1
        check(busy == 1'b0, "R1 busy after reset", 576'(busy), 576'd0);
        check(done == 1'b0, "R1 done after reset", 576'(done), 576'd0);
        check(z_out == '0, "R1 z after reset", 576'(z_out), 576'd0);
    endtask

    task automatic test_unit();
        logic [NL*AW-1:0] z;
        int lat;
        run_op(260'd1, 260'd1, 1'b0, 1'b0, z, lat);
        check(z == 320'd1, "R3 one times one limbs", 576'(z), 576'd1);
        check(lat == EXP_LAT_MUL, "R7 multiply latency", 576'(lat), 576'(EXP_LAT_MUL));
    endtask

    task automatic test_fold_low();
        logic [NL*AW-1:0] z;
        logic [NL*LW-1:0] a;
        logic [NL*LW-1:0] b;
        int lat;
        a = '0;
        b = '0;
        a[4*LW +: LW] = 52'd1;
        b[1*LW +: LW] = 52'd1;
        run_op(a, b, 1'b0, 1'b0, z, lat);
        check(z == 320'd19, "R4 fold at 2^255", 576'(z), 576'd19);
    endtask

    task automatic test_fold_top();
        logic [NL*AW-1:0] z;
        logic [NL*AW-1:0] exp;
        logic [NL*LW-1:0] a;
        int lat;
        a = '0;
        a[4*LW +: LW] = 52'h8_0000_0000_0000;
        exp = '0;
        exp[0 +: AW] = 64'd342;
        exp[4*AW +: AW] = 64'h0008_0000_0000_0000;
        run_op(a, a, 1'b0, 1'b0, z, lat);
        check(z == exp, "R5 two-stage top fold", 576'(z), 576'(exp));
        check_congruent("R2 top fold congruence", a, a, z);
    endtask

    task automatic test_random_mul();
        logic [NL*AW-1:0] z;
        logic [NL*LW-1:0] a;
        logic [NL*LW-1:0] b;
        int lat;
        for (int t = 0; t < 6; t++) begin
            a = rand_limbs();
            b = rand_limbs();
            if (t == 1) b = 260'd1;
            if (t == 2) a[4*LW +: LW] = '0;
            run_op(a, b, 1'b0, 1'b0, z, lat);
            check_congruent("R2 multiply congruence", a, b, z);
        end
    endtask

    task automatic test_square();
        logic [NL*AW-1:0] z;
        logic [NL*LW-1:0] a;
        int lat;
        run_op(260'd1, rand_limbs(), 1'b1, 1'b0, z, lat);
        check(z == 320'd1, "R6 square of one limbs", 576'(z), 576'd1);
        check(lat == EXP_LAT_SQR, "R7 square latency", 576'(lat), 576'(EXP_LAT_SQR));
        for (int t = 0; t < 4; t++) begin
            a = rand_limbs();
            run_op(a, rand_limbs(), 1'b1, 1'b0, z, lat);
            check_congruent("R6 square congruence", a, a, z);
        end
    endtask

    task automatic test_max();
        logic [NL*AW-1:0] z;
        logic [NL*LW-1:0] a;
        int lat;
        a = '1;
        run_op(a, a, 1'b0, 1'b0, z, lat);
        check_congruent("R10 all-max multiply", a, a, z);
        run_op(a, 260'd0, 1'b1, 1'b0, z, lat);
        check_congruent("R10 all-max square", a, a, z);
    endtask

    task automatic test_busy_start();
        logic [NL*AW-1:0] z;
        logic [NL*LW-1:0] a;
        logic [NL*LW-1:0] b;
        int lat;
        a = rand_limbs();
        b = rand_limbs();
        run_op(a, b, 1'b0, 1'b1, z, lat);
        check_congruent("R8 start while busy result", a, b, z);
        check(lat == EXP_LAT_MUL, "R8 start while busy timing", 576'(lat), 576'(EXP_LAT_MUL));
    endtask

    task automatic test_back_to_back();
        logic [NL*AW-1:0] z1;
        logic [NL*AW-1:0] z2;
        logic [NL*LW-1:0] a;
        logic [NL*LW-1:0] b;
        logic [NL*LW-1:0] c;
        int lat;
        a = rand_limbs();
        b = rand_limbs();
        c = rand_limbs();
        run_op(a, b, 1'b0, 1'b0, z1, lat);
        run_op(c, a, 1'b1, 1'b0, z2, lat);
        check_congruent("R2 first of back-to-back", a, b, z1);
        check_congruent("R6 second of back-to-back", c, c, z2);
        check(lat == EXP_LAT_SQR, "R7 back-to-back latency", 576'(lat), 576'(EXP_LAT_SQR));
    endtask

    task automatic test_hold();
        logic [NL*AW-1:0] z;
        logic [NL*LW-1:0] a;
        bit saw_done;
        int lat;
        a = rand_limbs();
        run_op(a, a, 1'b0, 1'b0, z, lat);
        saw_done = 1'b0;
        for (int t = 0; t < 6; t++) begin
            x_in = rand_limbs();
            y_in = rand_limbs();
            square = ~square;
            @(negedge clk);
            if (done) saw_done = 1'b1;
        end
        check(z_out == z, "R9 result held while idle", 576'(z_out), 576'(z));
        check(!saw_done, "R7 single done pulse", 576'(saw_done), 576'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_unit();
        test_fold_low();
        test_fold_top();
        test_random_mul();
        test_square();
        test_max();
        test_busy_start();
        test_back_to_back();
        test_hold();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule